// File: doc/BRIEF.md
# Flash Block Write-Protection Lock Controller

This block keeps a protection state for each erase block of a flash array. Each block is either open for program and erase, locked, or locked tight. A locked-tight block cannot be opened again until the next reset. Software writes a first-block and a last-block register. It then strobes a command code that opens the range, opens the whole array, locks the range or locks the range tight. The controller walks the selected blocks one per clock and updates each state as the command requires. It records the last state it wrote in a status word and ends every command with a one-cycle completion pulse.

Program and erase logic sit outside this block. They read a combinational query port to learn whether a target block may be altered. A range that walks past the last block of the array raises a command error. So does an unrecognised command code. The error stays visible until the next accepted command.

Top module: `wp_lock_ctrl`

## Requirements
- R1: Block states are one-hot 3-bit codes on `query_state`. Lock-tight is 3'b001, locked is 3'b010 and unlocked is 3'b100. `query_state` always shows the stored state of block `query_idx`.
- R2: After reset every block is locked and `wp_status` reads 16'h0002. `busy`, `done` and `cmd_err` are low, and both range registers read zero.
- R3: A write to the first-block register loads both range registers with the written value. A write to the last-block register loads only the last one. With `MASK_RANGE`=1 the stored value is the written value ANDed with `NUM_BLOCKS`-1. With `MASK_RANGE`=0 one more upper bit is kept.
- R4: Code 8'h23 opens blocks from first to last inclusive. The walk ends at the first lock-tight block it meets, and that block and every later one stay unchanged.
- R5: Code 8'h2A locks blocks from first to last inclusive. It ends at a lock-tight block in the same way as R4.
- R6: Code 8'h27 opens blocks from 0 to `NUM_BLOCKS`-1 and ignores the range registers. It ends at the first lock-tight block.
- R7: Code 8'h2C walks the range, passes over unlocked blocks without ending, and makes every other block lock-tight.
- R8: When the walk index reaches a block number of `NUM_BLOCKS` or more, `cmd_err` is set and the walk ends. `cmd_err` is cleared when the next command is accepted.
- R9: `wp_status` holds the state most recently written to any block, zero-extended to 16 bits. A command that writes no block leaves it unchanged.
- R10: The controller handles one block per clock. `busy` is high from the clock after the strobe through the last walk cycle. `done` is a one-cycle pulse in the cycle after that. A walk over n blocks raises `done` n+1 clocks after the strobe edge.
- R11: Any other code sets `cmd_err`, changes no block and pulses `done` in the cycle after the strobe, with `busy` staying low.
- R12: A command strobe that arrives while `busy` is high is ignored.
- R13: If the first block is greater than the last block, a range command changes no block, raises no error and pulses `done` two clocks after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that locks the whole array |
| start_wr | input | 1 | Write strobe for the first-block register (also loads the last-block register) |
| end_wr | input | 1 | Write strobe for the last-block register |
| range_wdata | input | 16 | Data for range register writes |
| cmd_valid | input | 1 | Command strobe, accepted only while idle |
| cmd_code | input | 8 | Command code |
| query_idx | input | log2(NUM_BLOCKS) | Block number to look up |
| query_state | output | 3 | One-hot state of the queried block |
| range_start | output | 16 | Stored first block, zero-extended |
| range_end | output | 16 | Stored last block, zero-extended |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Command error flag |
| wp_status | output | 16 | Last state written to a block |

## Verification
The bench builds two copies of the block, both with `NUM_BLOCKS`=16, so that a full-array walk stays short and every block can be checked through the query port. The first copy uses `MASK_RANGE`=1 and covers truncation of range writes and all the sweep orderings. These include stops at lock-tight blocks, unlocked blocks passed over, reversed ranges and strobes sent while busy. The second copy uses `MASK_RANGE`=0. Its range registers can then hold numbers past the array, which is the only way to make a walk run off the end and raise the overrun error.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

   typedef enum logic [2:0] {
      LK_TIGHT  = 3'b001,
      LK_LOCKED = 3'b010,
      LK_OPEN   = 3'b100
   } lock_state_t;

   typedef enum logic [1:0] {
      SW_OPEN  = 2'd0,
      SW_LOCK  = 2'd1,
      SW_TIGHT = 2'd2
   } sweep_mode_t;

   localparam logic [7:0] OP_OPEN_RANGE  = 8'h23;
   localparam logic [7:0] OP_OPEN_ALL    = 8'h27;
   localparam logic [7:0] OP_LOCK_RANGE  = 8'h2A;
   localparam logic [7:0] OP_TIGHT_RANGE = 8'h2C;

   localparam logic [15:0] WP_RESET_VALUE = 16'h0002;

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
   parameter int NUM_BLOCKS = 16,
   parameter bit MASK_RANGE = 1'b1,
   parameter int RW         = $clog2(NUM_BLOCKS) + (MASK_RANGE ? 0 : 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_wr,
   input  logic          end_wr,
   input  logic [15:0]   wdata,
   output logic [RW-1:0] first_q,
   output logic [RW-1:0] last_q
);

   logic [RW-1:0] wval;

   generate
      if (MASK_RANGE) begin : g_masked
         // Truncation to log2(N) bits is the AND with N-1 for a power of two
         assign wval = wdata[RW-1:0] & RW'(NUM_BLOCKS - 1);
      end else begin : g_wide
         assign wval = wdata[RW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
      end else begin
         if (start_wr) begin
            first_q <= wval;
            last_q  <= wval;
         end else if (end_wr) begin
            last_q <= wval;
         end
      end
   end

   AST_END_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (last_q == first_q)); // R3

endmodule

// File: rtl/wp_block_array.sv
module wp_block_array
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter int BW         = $clog2(NUM_BLOCKS)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [BW-1:0] wr_idx,
   input  lock_state_t wr_state,
   input  logic [BW-1:0] rd_idx,
   output lock_state_t rd_state,
   input  logic [BW-1:0] q_idx,
   output lock_state_t q_state
);

   lock_state_t blk_q [NUM_BLOCKS];

   generate
      for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               blk_q[g] <= LK_LOCKED;
            end else if (wr_en && (wr_idx == BW'(g))) begin
               blk_q[g] <= wr_state;
            end
         end

         AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(blk_q[g])); // R1
         AST_TIGHT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_q[g] == LK_TIGHT) |=> (blk_q[g] == LK_TIGHT)); // R4
      end
   endgenerate

   assign rd_state = blk_q[rd_idx];
   assign q_state  = blk_q[q_idx];

endmodule

// File: rtl/wp_sweep_ctrl.sv
module wp_sweep_ctrl
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter int RW         = 4,
   parameter int BW         = $clog2(NUM_BLOCKS),
   parameter int IW         = BW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [7:0]    cmd_code,
   input  logic [RW-1:0] first_blk,
   input  logic [RW-1:0] last_blk,
   input  lock_state_t   cur_state,
   output logic [BW-1:0] rd_idx,
   output logic          wr_en,
   output logic [BW-1:0] wr_idx,
   output lock_state_t   wr_state,
   output logic          busy,
   output logic          done,
   output logic          cmd_err,
   output logic [15:0]   wp_status
);

   logic [IW-1:0] idx_q;
   logic [IW-1:0] end_q;
   sweep_mode_t   mode_q;
   logic          run_q;
   logic          done_q;
   logic          err_q;
   logic [15:0]   wp_q;

   logic          accept;
   logic          known_op;
   logic          finish;
   logic          ovf_hit;
   logic          past_end;
   lock_state_t   target;

   assign accept = cmd_valid && !run_q;

   always_comb begin
      case (cmd_code)
         OP_OPEN_RANGE, OP_OPEN_ALL, OP_LOCK_RANGE, OP_TIGHT_RANGE: known_op = 1'b1;
         default: known_op = 1'b0;
      endcase
   end

   always_comb begin
      case (mode_q)
         SW_OPEN:  target = LK_OPEN;
         SW_LOCK:  target = LK_LOCKED;
         default:  target = LK_TIGHT;
      endcase
   end

   assign past_end = (idx_q > end_q);
   assign rd_idx   = idx_q[BW-1:0];
   assign wr_idx   = idx_q[BW-1:0];
   assign wr_state = target;

   // One block per clock: decide stop, write and error for the current index
   always_comb begin
      wr_en   = 1'b0;
      finish  = 1'b0;
      ovf_hit = 1'b0;
      if (run_q) begin
         if (past_end) begin
            finish = 1'b1;
         end else if (idx_q >= IW'(NUM_BLOCKS)) begin
            ovf_hit = 1'b1;
            finish  = 1'b1;
         end else begin
            if (mode_q == SW_TIGHT) begin
               wr_en = (cur_state != LK_OPEN);
            end else if (cur_state == LK_TIGHT) begin
               finish = 1'b1;
            end else begin
               wr_en = 1'b1;
            end
            if (idx_q == end_q) begin
               finish = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         end_q  <= '0;
         mode_q <= SW_OPEN;
         run_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         wp_q   <= WP_RESET_VALUE;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            err_q <= !known_op;
            if (known_op) begin
               run_q <= 1'b1;
               if (cmd_code == OP_OPEN_ALL) begin
                  idx_q <= '0;
                  end_q <= IW'(NUM_BLOCKS - 1);
               end else begin
                  idx_q <= IW'(first_blk);
                  end_q <= IW'(last_blk);
               end
               case (cmd_code)
                  OP_LOCK_RANGE:  mode_q <= SW_LOCK;
                  OP_TIGHT_RANGE: mode_q <= SW_TIGHT;
                  default:        mode_q <= SW_OPEN;
               endcase
            end else begin
               done_q <= 1'b1;
            end
         end else if (run_q) begin
            if (wr_en) begin
               wp_q <= {13'd0, target};
            end
            if (ovf_hit) begin
               err_q <= 1'b1;
            end
            if (finish) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy      = run_q;
   assign done      = done_q;
   assign cmd_err   = err_q;
   assign wp_status = wp_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R10
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err) |-> done); // R8
   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R12
   AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(wp_status[2:0]) && (wp_status[15:3] == 13'd0)); // R9

endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
   import wp_lock_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter bit MASK_RANGE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_wr,
   input  logic                          end_wr,
   input  logic [15:0]                   range_wdata,
   input  logic                          cmd_valid,
   input  logic [7:0]                    cmd_code,
   input  logic [$clog2(NUM_BLOCKS)-1:0] query_idx,
   output logic [2:0]                    query_state,
   output logic [15:0]                   range_start,
   output logic [15:0]                   range_end,
   output logic                          busy,
   output logic                          done,
   output logic                          cmd_err,
   output logic [15:0]                   wp_status
);

   localparam int BW = $clog2(NUM_BLOCKS);
   localparam int RW = BW + (MASK_RANGE ? 0 : 1);
   localparam int IW = BW + 1;

   initial begin
      assert (NUM_BLOCKS >= 2 && (NUM_BLOCKS & (NUM_BLOCKS - 1)) == 0)
         else $error("NUM_BLOCKS must be a power of two of at least 2");
      assert (RW <= 15) else $error("range registers exceed 15 bits");
   end

   logic [RW-1:0] first_q;
   logic [RW-1:0] last_q;
   logic [BW-1:0] rd_idx;
   logic [BW-1:0] wr_idx;
   logic          wr_en;
   lock_state_t   wr_state;
   lock_state_t   rd_state;
   lock_state_t   q_state;

   wp_range_regs #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .MASK_RANGE (MASK_RANGE),
      .RW         (RW)
   ) u_range (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_wr (start_wr),
      .end_wr   (end_wr),
      .wdata    (range_wdata),
      .first_q  (first_q),
      .last_q   (last_q)
   );

   wp_block_array #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .BW         (BW)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_state (wr_state),
      .rd_idx   (rd_idx),
      .rd_state (rd_state),
      .q_idx    (query_idx),
      .q_state  (q_state)
   );

   wp_sweep_ctrl #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .RW         (RW),
      .BW         (BW),
      .IW         (IW)
   ) u_sweep (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .first_blk (first_q),
      .last_blk  (last_q),
      .cur_state (rd_state),
      .rd_idx    (rd_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_state  (wr_state),
      .busy      (busy),
      .done      (done),
      .cmd_err   (cmd_err),
      .wp_status (wp_status)
   );

   assign query_state = q_state;
   assign range_start = 16'(first_q);
   assign range_end   = 16'(last_q);

   AST_RESET_LOCKED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (wp_status == WP_RESET_VALUE)); // R2

endmodule

// File: tb/tb_wp_lock_ctrl.sv
module tb_wp_lock_ctrl;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_wr = 1'b0, end_wr = 1'b0, cmd_valid = 1'b0;
   logic [15:0] range_wdata = '0;
   logic [7:0]  cmd_code = '0;
   logic [3:0]  query_idx = '0;
   logic [2:0]  query_state;
   logic [15:0] range_start, range_end, wp_status;
   logic        busy, done, cmd_err;

   logic        o_start_wr = 1'b0, o_end_wr = 1'b0, o_cmd_valid = 1'b0;
   logic [15:0] o_wdata = '0;
   logic [7:0]  o_code = '0;
   logic [3:0]  o_qidx = '0;
   logic [2:0]  o_qstate;
   logic [15:0] o_rs, o_re, o_wp;
   logic        o_busy, o_done, o_err;

   int errors = 0;
   int checks = 0;
   logic [2:0] exp_st [N];
   logic [15:0] exp_wp;

   always #5 clk = ~clk;

   wp_lock_ctrl #(.NUM_BLOCKS(N), .MASK_RANGE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
      .range_wdata(range_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .query_idx(query_idx), .query_state(query_state), .range_start(range_start),
      .range_end(range_end), .busy(busy), .done(done), .cmd_err(cmd_err),
      .wp_status(wp_status));

   wp_lock_ctrl #(.NUM_BLOCKS(N), .MASK_RANGE(1'b0)) dut_ovf (
      .clk(clk), .rst_n(rst_n), .start_wr(o_start_wr), .end_wr(o_end_wr),
      .range_wdata(o_wdata), .cmd_valid(o_cmd_valid), .cmd_code(o_code),
      .query_idx(o_qidx), .query_state(o_qstate), .range_start(o_rs),
      .range_end(o_re), .busy(o_busy), .done(o_done), .cmd_err(o_err),
      .wp_status(o_wp));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_blocks(input string req);
      int bad = 0;
      for (int i = 0; i < N; i++) begin
         query_idx = 4'(i);
         #1;
         if (query_state !== exp_st[i]) begin
            bad++;
            $display("FAIL %s block %0d: actual=%0b expected=%0b", req, i, query_state, exp_st[i]);
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   task automatic write_range(input logic [15:0] s, input logic [15:0] e);
      @(negedge clk);
      range_wdata = s; start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0; range_wdata = e; end_wr = 1'b1;
      @(negedge clk);
      end_wr = 1'b0;
   endtask

   // Requirement model: walk the expected array, return error and latency
   task automatic model(input logic [7:0] code, input int s, input int e,
                        output logic err, output int lat);
      int lo, hi, i, n;
      err = 1'b0; n = 0;
      if (!(code == 8'h23 || code == 8'h27 || code == 8'h2A || code == 8'h2C)) begin
         err = 1'b1; lat = 1; return;
      end
      lo = (code == 8'h27) ? 0 : s;
      hi = (code == 8'h27) ? N - 1 : e;
      i = lo;
      forever begin
         n++;
         if (i > hi) break;
         if (i >= N) begin err = 1'b1; break; end
         if (code == 8'h2C) begin
            if (exp_st[i] != 3'b100) begin exp_st[i] = 3'b001; exp_wp = 16'h0001; end
         end else if (exp_st[i] == 3'b001) begin
            break;
         end else begin
            exp_st[i] = (code == 8'h2A) ? 3'b010 : 3'b100;
            exp_wp = {13'd0, exp_st[i]};
         end
         if (i == hi) break;
         i++;
      end
      lat = n + 1;
   endtask

   // Issue a command; optionally inject a second strobe mid-walk; return clocks to done
   task automatic issue(input logic [7:0] code, input bit inject, output int lat, output bit saw_busy);
      lat = 0; saw_busy = 0;
      @(negedge clk);
      cmd_code = code; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      forever begin
         lat++;
         if (lat == 1 && busy) saw_busy = 1;
         if (inject && lat == 3) begin cmd_code = 8'h2A; cmd_valid = 1'b1; end
         if (inject && lat == 4) cmd_valid = 1'b0;
         if (done || lat > 100) break;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
   endtask

   task automatic run_case(input string req, input logic [7:0] code, input int s, input int e, input bit inject);
      logic eerr; int elat, alat; bit sb;
      model(code, s, e, eerr, elat);
      issue(code, inject, alat, sb);
      chk(req, "done latency", 32'(alat), 32'(elat));
      chk(req, "cmd_err", 32'(cmd_err), 32'(eerr));
      chk(req, "wp_status", 32'(wp_status), 32'(exp_wp));
      chk("R10", "busy after strobe", 32'(sb), 32'(elat > 1));
      @(negedge clk);
      chk("R10", "done one cycle", 32'(done), 32'd0);
      check_blocks(req);
   endtask

   task automatic t_reset;
      chk("R2", "wp_status", 32'(wp_status), 32'h0002);
      chk("R2", "busy/done/err", {29'd0, busy, done, cmd_err}, 32'd0);
      chk("R2", "range regs", {range_start, range_end}, 32'd0);
      check_blocks("R2 R1");
   endtask

   task automatic t_range_regs;
      write_range(16'd5, 16'd9);
      chk("R3", "start", 32'(range_start), 32'd5);
      chk("R3", "end after end write", 32'(range_end), 32'd9);
      @(negedge clk); range_wdata = 16'h0013; start_wr = 1'b1;
      @(negedge clk); start_wr = 1'b0;
      chk("R3", "start masked", 32'(range_start), 32'd3);
      chk("R3", "end follows start", 32'(range_end), 32'd3);
   endtask

   task automatic t_overrun;
      int lat = 0;
      @(negedge clk); o_wdata = 16'd14; o_start_wr = 1'b1;
      @(negedge clk); o_start_wr = 1'b0; o_wdata = 16'd17; o_end_wr = 1'b1;
      @(negedge clk); o_end_wr = 1'b0;
      chk("R3", "wide end kept", 32'(o_re), 32'd17);
      o_code = 8'h23; o_cmd_valid = 1'b1;
      @(negedge clk); o_cmd_valid = 1'b0;
      forever begin
         lat++;
         if (o_done || lat > 100) break;
         @(negedge clk);
      end
      chk("R8", "overrun latency", 32'(lat), 32'd4);
      chk("R8", "cmd_err on overrun", 32'(o_err), 32'd1);
      chk("R9", "wp after overrun", 32'(o_wp), 32'h0004);
      o_qidx = 4'd15; #1;
      chk("R8", "block 15 opened", 32'(o_qstate), 32'b100);
      o_qidx = 4'd13; #1;
      chk("R8", "block 13 untouched", 32'(o_qstate), 32'b010);
   endtask

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) exp_st[i] = 3'b010;
      exp_wp = 16'h0002;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_range_regs();
      run_case("R6 R12", 8'h27, 0, 0, 1'b1);          // open all, ignored strobe mid-walk
      write_range(16'd2, 16'd5);
      run_case("R5", 8'h2A, 2, 5, 1'b0);
      write_range(16'd0, 16'd7);
      run_case("R7", 8'h2C, 0, 7, 1'b0);
      write_range(16'd0, 16'd9);
      run_case("R5 stop", 8'h2A, 0, 9, 1'b0);
      write_range(16'd0, 16'd3);
      run_case("R4 stop", 8'h23, 0, 3, 1'b0);
      run_case("R6 stop", 8'h27, 0, 0, 1'b0);
      write_range(16'd9, 16'd4);
      run_case("R13 R9", 8'h2A, 9, 4, 1'b0);
      run_case("R11", 8'h55, 9, 4, 1'b0);
      write_range(16'd9, 16'd9);
      run_case("R8 R4 clear", 8'h23, 9, 9, 1'b0);
      t_overrun();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule